// File: doc/BRIEF.md
# Serial Conversion Result Read Port

This block lets a host read the most recent conversion result over three wires: an active-low read select, a serial clock driven by the host, and a serial data output. The output is tri-state. The result producer presents a new result with a one-cycle strobe, and the block keeps the latest one. When the host pulls the read select low, the block copies that result into an output shift register and drives the first bit. No serial clock edge is needed for that first bit. After that, each falling serial clock edge moves the next bit onto the output. The host can raise the read select at any point to end the read. While the read select is high the output pad is released.

The frame is 18 bits long and goes out in this order:
- the overrange flag;
- the polarity flag (1 means the input was positive);
- the 16-bit magnitude, most significant bit first.

The read select and the serial clock both come from the host and are asynchronous to the system clock. Each passes through a two-flop synchronizer, and its edges are detected in the system clock domain. The system clock must therefore run at least four times faster than the serial clock.

A three-state machine controls the read:
- **IDLE**: the pad is released.
- **SHIFT**: frame bits are being sent.
- **DRAINED**: all 18 bits have gone out and the pad still drives zeros.

The transitions are:
- **OPEN** (IDLE to SHIFT) on a synchronized fall of the read select. This loads the snapshot.
- **ADVANCE** (SHIFT to SHIFT) on each synchronized fall of the serial clock.
- **EXHAUST** (SHIFT to DRAINED) once 18 shifts have been counted.
- **ABORT** (SHIFT or DRAINED to IDLE) whenever the synchronized read select is high. ABORT clears the shift register.

The block does not have a real tri-state pad. It drives `sdo_oe` as the enable for an external pad buffer, and it holds `sdo` at 0 while that enable is low.

Top module: `result_readout_port`

## Requirements
- R1: After reset, `sdo_oe` and `sdo` are 0. A read made before any result strobe returns 18 zero bits.
- R2: Each cycle with `res_valid` high replaces the held result. A read returns the result of the last strobe before the read select fell.
- R3: Bit 0 of the frame is overrange, bit 1 is polarity (1 = positive), and bits 2 to 17 are the magnitude from bit 15 down to bit 0.
- R4: Suppose `rd_sel_n` falls before a rising clock edge. Then `sdo_oe` is still 0 after two rising edges. After the third rising edge, `sdo_oe` is 1 and `sdo` carries the overrange bit. No serial clock edge is needed.
- R5: Each falling edge of `sclk` during a read advances the output by exactly one bit, visible by the third rising clock edge after that edge. A rising edge of `sclk` leaves `sdo` unchanged.
- R6: Whenever the synchronized `rd_sel_n` is high, `sdo_oe` is 0 and `sdo` is 0 from the following clock.
- R7: Raising `rd_sel_n` partway through a frame ends the read. The next read starts again from the overrange bit of a fresh snapshot.
- R8: A result strobe during a read does not change the frame being read. It takes effect only at the next fall of the read select.
- R9: After all 18 bits have been sent, later falling `sclk` edges produce 0 on `sdo`, and `sdo_oe` stays 1.
- R10: `sclk` activity while `rd_sel_n` is high has no effect. The next read still starts at the overrange bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe: a new result is on the result inputs |
| res_ovr | input | 1 | Overrange flag of the new result |
| res_pos | input | 1 | Polarity of the new result, 1 = positive |
| res_mag | input | 16 | Magnitude of the new result |
| rd_sel_n | input | 1 | Host read select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| sdo | output | 1 | Serial data bit, 0 while not enabled |
| sdo_oe | output | 1 | Pad drive enable; the pad is high-impedance when 0 |

## Verification
The bench goes after the following corner cases:
- **Exact latency of the first bit.** A design that waits for a serial clock edge before driving the overrange bit would be caught. So would one that adds or drops a synchronizer stage, because the bench samples at the third clock edge after the read select falls.
- **Result strobe in the middle of a read.** A design that reloads from the live result would show the new bits part way through the frame.
- **Aborts after a random number of bits.** A design that keeps its bit position across reads would start the next frame part way along.
- **Reading past the end of the frame.** A design whose counter wraps would repeat the frame instead of driving zeros.
- **Rising serial clock edges.** A design that shifts on the wrong edge would move the output while the serial clock is high.
- **Serial clock toggling while the read select is high.** A design that shifts while idle would lose the leading bits of the next read.

// File: rtl/rrp_pkg.sv
package rrp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SHIFT   = 2'd1,
        ST_DRAINED = 2'd2
    } rd_state_e;
endpackage

// File: rtl/rrp_sync_edge.sv
// Brings one asynchronous level into the clk domain and flags its falling edge.
module rrp_sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic fell_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign fell_o  = prev_q & ~chain_q[STAGES-1];

    initial begin
        assert (STAGES >= 2) else $error("synchronizer needs at least two stages");
    end
endmodule

// File: rtl/rrp_result_hold.sv
// Keeps the latest result presented by the producer, packed in frame order.
module rrp_result_hold #(
    parameter int MAG_W = 16,
    localparam int FRAME_W = MAG_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_i,
    input  logic               ovr_i,
    input  logic               pos_i,
    input  logic [MAG_W-1:0]   mag_i,
    output logic [FRAME_W-1:0] frame_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     frame_o <= '0;
        else if (upd_i) frame_o <= {ovr_i, pos_i, mag_i};
    end

    p_hold_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(frame_o));
    p_hold_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> frame_o[FRAME_W-1] == $past(ovr_i) && frame_o[MAG_W-1:0] == $past(mag_i));
endmodule

// File: rtl/rrp_frame_shifter.sv
// Output shift register with a count of how many shifts have been made.
module rrp_frame_shifter #(
    parameter int FRAME_W = 18,
    localparam int CNT_W = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               load_i,
    input  logic               shift_i,
    input  logic [FRAME_W-1:0] din_i,
    output logic               bit_o,
    output logic               done_o
);
    logic [FRAME_W-1:0] sreg_q;
    logic [CNT_W-1:0]   cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (clear_i) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            sreg_q <= din_i;
            cnt_q  <= '0;
        end else if (shift_i) begin
            sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
            if (cnt_q != CNT_W'(FRAME_W)) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bit_o  = sreg_q[FRAME_W-1];
    assign done_o = (cnt_q == CNT_W'(FRAME_W));

    p_load_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clear_i) |=> bit_o == $past(din_i[FRAME_W-1]));
    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(FRAME_W));
    p_done_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !bit_o);
endmodule

// File: rtl/rrp_read_fsm.sv
// Read sequencer: IDLE --OPEN--> SHIFT --EXHAUST--> DRAINED, ABORT back to IDLE.
module rrp_read_fsm
    import rrp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel_high_i,
    input  logic      sel_fall_i,
    input  logic      sclk_fall_i,
    input  logic      frame_done_i,
    output logic      load_o,
    output logic      shift_o,
    output logic      clear_o,
    output logic      oe_o,
    output rd_state_e state_o
);
    rd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (sel_fall_i)        state_d = ST_SHIFT;    // OPEN
            ST_SHIFT:   if (sel_high_i)        state_d = ST_IDLE;     // ABORT
                        else if (frame_done_i) state_d = ST_DRAINED;  // EXHAUST
            ST_DRAINED: if (sel_high_i)        state_d = ST_IDLE;     // ABORT
            default:                           state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o  = 1'b0;
        shift_o = 1'b0;
        clear_o = 1'b0;
        oe_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_o  = sel_fall_i;
                clear_o = !sel_fall_i;
            end
            ST_SHIFT, ST_DRAINED: begin
                oe_o    = 1'b1;
                clear_o = sel_high_i;
                shift_o = !sel_high_i && sclk_fall_i;    // ADVANCE
            end
            default: clear_o = 1'b1;
        endcase
    end

    assign state_o = state_q;

    p_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_high_i |=> state_q == ST_IDLE);
    p_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && sel_fall_i) |=> state_q == ST_SHIFT);
    p_idle_no_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> !shift_o);
endmodule

// File: rtl/result_readout_port.sv
module result_readout_port
    import rrp_pkg::*;
#(
    parameter int MAG_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic             res_ovr,
    input  logic             res_pos,
    input  logic [MAG_W-1:0] res_mag,
    input  logic             rd_sel_n,
    input  logic             sclk,
    output logic             sdo,
    output logic             sdo_oe
);
    localparam int FRAME_W = MAG_W + 2;

    logic               sel_lvl, sel_fall, sck_lvl, sck_fall;
    logic [FRAME_W-1:0] held_frame;
    logic               load, shift, clear, done;
    rd_state_e          state;

    rrp_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .async_i(rd_sel_n),
        .level_o(sel_lvl), .fell_o(sel_fall));

    rrp_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .async_i(sclk),
        .level_o(sck_lvl), .fell_o(sck_fall));

    rrp_result_hold #(.MAG_W(MAG_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .upd_i(res_valid),
        .ovr_i(res_ovr), .pos_i(res_pos), .mag_i(res_mag),
        .frame_o(held_frame));

    rrp_read_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sel_high_i(sel_lvl), .sel_fall_i(sel_fall),
        .sclk_fall_i(sck_fall), .frame_done_i(done),
        .load_o(load), .shift_o(shift), .clear_o(clear),
        .oe_o(sdo_oe), .state_o(state));

    rrp_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .clear_i(clear), .load_i(load), .shift_i(shift),
        .din_i(held_frame), .bit_o(sdo), .done_o(done));

    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);
    p_sdo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(load || shift || clear) |=> $stable(sdo));
    p_shift_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !sck_lvl);
    p_drained_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DRAINED |-> (!sdo && sdo_oe));
endmodule

// File: tb/result_readout_port_tb_top.sv
module result_readout_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0, res_ovr = 1'b0, res_pos = 1'b0;
    logic [15:0] res_mag = '0;
    logic        rd_sel_n = 1'b1, sclk = 1'b0;
    logic        sdo, sdo_oe;
    int          checks = 0, errors = 0;
    logic [17:0] model_frame = '0;

    always #2.5 clk = ~clk;

    result_readout_port dut_i (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ovr(res_ovr),
        .res_pos(res_pos), .res_mag(res_mag), .rd_sel_n(rd_sel_n), .sclk(sclk),
        .sdo(sdo), .sdo_oe(sdo_oe));

    function automatic logic exp_bit(logic [17:0] f, int k);
        return (k < 18) ? f[17-k] : 1'b0;
    endfunction

    task automatic check(logic act, logic exp, string req, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(logic o, logic p, logic [15:0] m);
        @(negedge clk);
        res_valid = 1'b1; res_ovr = o; res_pos = p; res_mag = m;
        @(negedge clk);
        res_valid = 1'b0;
        model_frame = {o, p, m};
    endtask

    // Opens a read, takes nbits falling edges, optionally pushes a result mid-read, then closes.
    task automatic read_frame(int nbits, bit mid_push, string req);
        logic [17:0] snap = model_frame;
        @(negedge clk); rd_sel_n = 1'b0;
        wait_n(4);
        check(sdo_oe, 1'b1, "R4", "enable after open");
        check(sdo, exp_bit(snap, 0), req, "bit 0 (overrange)");
        for (int k = 1; k <= nbits; k++) begin
            sclk = 1'b1; wait_n(4);
            check(sdo, exp_bit(snap, k-1), "R5", "rising sclk must not advance");
            if (mid_push && k == 3)
                push(1'($urandom), 1'($urandom), 16'($urandom));   // R8
            sclk = 1'b0; wait_n(4);
            check(sdo, exp_bit(snap, k), (k < 18) ? (mid_push ? "R8" : req) : "R9", "frame bit");
            if (k >= 18) check(sdo_oe, 1'b1, "R9", "enable held past frame end");
        end
        rd_sel_n = 1'b1; wait_n(4);
        check(sdo_oe, 1'b0, "R6", "enable after close");
        check(sdo, 1'b0, "R7", "data after close");
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        wait_n(3); rst_n = 1'b1; wait_n(2);
        check(sdo_oe, 1'b0, "R1", "reset enable");
        check(sdo, 1'b0, "R1", "reset data");
        read_frame(18, 1'b0, "R1");

        // R4: exact latency of the first bit
        push(1'b1, 1'b0, 16'hA5C3);
        @(negedge clk); rd_sel_n = 1'b0;
        @(negedge clk); check(sdo_oe, 1'b0, "R4", "enable after one edge");
        @(negedge clk); check(sdo_oe, 1'b0, "R4", "enable after two edges");
        @(negedge clk); check(sdo_oe, 1'b1, "R4", "enable after three edges");
        check(sdo, 1'b1, "R4", "overrange on third edge");
        rd_sel_n = 1'b1; wait_n(4);

        // R10: serial clock toggling while deselected
        for (int i = 0; i < 5; i++) begin sclk = 1'b1; wait_n(4); sclk = 1'b0; wait_n(4); end
        read_frame(4, 1'b0, "R10");

        // R3: distinct bit pattern through the full frame
        push(1'b0, 1'b1, 16'h8001);
        read_frame(18, 1'b0, "R3");

        // R8: update in the middle of a read
        push(1'b1, 1'b1, 16'h3C96);
        read_frame(18, 1'b1, "R8");

        // R7: abort partway, then the next read starts at bit 0
        push(1'b1, 1'b0, 16'h7FFE);
        read_frame(7, 1'b0, "R7");
        read_frame(2, 1'b0, "R7");

        // R2: several strobes, the last one wins
        push(1'b0, 1'b0, 16'h1111);
        push(1'b1, 1'b1, 16'h2222);
        push(1'b0, 1'b1, 16'hC0DE);
        read_frame(18, 1'b0, "R2");

        // R9: read past the end of the frame
        push(1'b1, 1'b1, 16'hFFFF);
        read_frame(21, 1'b0, "R9");

        for (int it = 0; it < 40; it++) begin
            push(1'($urandom), 1'($urandom), 16'($urandom));
            if ($urandom_range(0, 3) == 0) push(1'($urandom), 1'($urandom), 16'($urandom));
            read_frame($urandom_range(0, 22), ($urandom_range(0, 3) == 0), "R3");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL all watchdog: actual still running, expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule